// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block holds the addressing state for two independent memory buses, one generator per bus. Each generator keeps a file of circular-buffer descriptors (pointer, signed step, length, start address). When a bus asks for an address it names a descriptor slot. The generator presents that slot's current pointer as the address and moves the pointer on by its step at the next clock edge. If the moved pointer leaves the buffer at either end, the generator folds it back in. No software bounds check is needed, so a constant step walks a delay line or a filter history forever.

Buffers may start at any address and may have any length, including odd lengths, with no alignment rule. Each generator has a primary and a secondary copy of its descriptor file. A per-generator select input chooses which copy the requests use, so a context switch costs one cycle and saves nothing to memory. A single configuration port writes and reads back every register of either copy of either generator.

Top module: `circ_agen`

## Requirements
- R1: For each generator g, while `req_i[g]` is high, `addr_o[g*AW +: AW]` shows in the same cycle the pointer of the slot `idx_i[g*IW +: IW]` in that generator's active bank, taken before this request's update.
- R2: At the clock edge that ends a requesting cycle, the requested pointer becomes its post-modified value. The step is the slot's modifier read as a two's-complement number.
- R3: With length L nonzero, base B, and a pointer inside [B, B+L) whose modifier has magnitude at most L, the sum is reduced by L when it is at or above B+L and raised by L when it is below B. The pointer therefore stays inside the buffer for any B and any L.
- R4: With length zero the pointer is simply pointer plus modifier, modulo 2^AW, with no wrapping at any buffer edge.
- R5: Writing a slot's base register also loads that slot's pointer with the same value.
- R6: The value on `bank_sel_i[g]` at a clock edge picks the bank used from the following cycle. The current cycle still uses the old bank. After reset the primary bank (0) is active.
- R7: Requests change only the active bank. Every register of the inactive bank keeps its value.
- R8: Reset clears every register of both banks of both generators to zero.
- R9: When a configuration write and a request target the same pointer in the same cycle, the written value is kept. A write to the modifier, length or base only affects requests in later cycles, because the current request uses the old values.
- R10: The two generators are independent. Requests to both in the same cycle each advance their own pointer.
- R11: `cfg_rdata_o` shows, in the same cycle, the register chosen by `cfg_gen_i`, `cfg_bank_i` (0 primary, 1 secondary), `cfg_idx_i` and `cfg_kind_i`. The kind codes are 0 pointer, 1 modifier, 2 length and 3 base. A write with `cfg_we_i` high uses the same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_i | input | NGEN | Per-generator bank choice, 0 primary, 1 secondary |
| req_i | input | NGEN | Per-generator access request |
| idx_i | input | NGEN*IW | Per-generator slot index |
| addr_o | output | NGEN*AW | Per-generator address, pointer before update |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_gen_i | input | GW | Generator selected for configuration access |
| cfg_bank_i | input | 1 | Bank selected for configuration access |
| cfg_kind_i | input | 2 | Register kind: 0 pointer, 1 modifier, 2 length, 3 base |
| cfg_idx_i | input | IW | Slot selected for configuration access |
| cfg_wdata_i | input | AW | Configuration write data |
| cfg_rdata_o | output | AW | Configuration read data |

## Verification
A post-modify update and a configuration write can land on the same slot in the same cycle. The bench raises a request and a write to that slot's pointer, modifier or base on one clock edge. It then reads the pointer back and follows the next addresses. It expects the written pointer or base to win, and it expects the old modifier to drive the update in progress. A bank switch can also coincide with a request. The bench expects the address in the switching cycle to come from the old bank, and the bank that was left to keep its contents.

// File: rtl/agen_pkg.sv
package agen_pkg;

    // Register kind codes used by the configuration port.
    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_MOD  = 2'd1,
        REG_LEN  = 2'd2,
        REG_BASE = 2'd3
    } reg_kind_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/agen_wrap.sv
// Post-modify with fold-back into [base, base+len); len == 0 means linear.
module agen_wrap #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] mod_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] nxt_o
);
    localparam int unsigned EW = AW + 2;

    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lo;
    logic signed [EW-1:0] hi;
    logic signed [EW-1:0] len_x;
    logic signed [EW-1:0] res;

    always_comb begin
        sum   = $signed({2'b00, ptr_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
        lo    = $signed({2'b00, base_i});
        len_x = $signed({2'b00, len_i});
        hi    = lo + len_x;
        res   = sum;
        if (len_i != '0) begin
            if (sum >= hi) begin
                res = sum - len_x;
            end else if (sum < lo) begin
                res = sum + len_x;
            end
        end
        nxt_o = AW'(res);
    end

endmodule

// File: rtl/agen_unit.sv
// One generator: two banks of descriptor slots plus the active-bank flag.
module agen_unit
    import agen_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bank_sel_i,
    input  logic            req_i,
    input  logic [IW-1:0]   idx_i,
    input  logic            we_i,
    input  logic            cfg_bank_i,
    input  reg_kind_e       cfg_kind_i,
    input  logic [IW-1:0]   cfg_idx_i,
    input  logic [AW-1:0]   wdata_i,
    output logic [AW-1:0]   rdata_o,
    output logic [AW-1:0]   addr_o,
    output logic [AW-1:0]   nxt_o,
    output logic [AW-1:0]   mod_o,
    output logic [AW-1:0]   len_o,
    output logic [AW-1:0]   base_o,
    output logic            bank_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] mod;
        logic [AW-1:0] len;
        logic [AW-1:0] base;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_BANKS-1:0][SLOTS-1:0] rf;
        logic                             bank;
    } state_t;

    state_t st_d;
    state_t st_q;
    slot_t  cur;
    slot_t  sel;
    logic [AW-1:0] nxt;

    assign cur = st_q.rf[st_q.bank][idx_i];
    assign sel = st_q.rf[cfg_bank_i][cfg_idx_i];

    agen_wrap #(.AW(AW)) u_wrap (
        .ptr_i  (cur.ptr),
        .mod_i  (cur.mod),
        .len_i  (cur.len),
        .base_i (cur.base),
        .nxt_o  (nxt)
    );

    // Next-state: bank flag, then request update, then configuration write
    // (the write is applied last so it overrides a same-cycle update).
    always_comb begin
        st_d      = st_q;
        st_d.bank = bank_sel_i;
        if (req_i) begin
            st_d.rf[st_q.bank][idx_i].ptr = nxt;
        end
        if (we_i) begin
            unique case (cfg_kind_i)
                REG_PTR:  st_d.rf[cfg_bank_i][cfg_idx_i].ptr = wdata_i;
                REG_MOD:  st_d.rf[cfg_bank_i][cfg_idx_i].mod = wdata_i;
                REG_LEN:  st_d.rf[cfg_bank_i][cfg_idx_i].len = wdata_i;
                REG_BASE: begin
                    st_d.rf[cfg_bank_i][cfg_idx_i].base = wdata_i;
                    st_d.rf[cfg_bank_i][cfg_idx_i].ptr  = wdata_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (cfg_kind_i)
            REG_PTR:  rdata_o = sel.ptr;
            REG_MOD:  rdata_o = sel.mod;
            REG_LEN:  rdata_o = sel.len;
            REG_BASE: rdata_o = sel.base;
            default:  rdata_o = '0;
        endcase
    end

    assign addr_o = cur.ptr;
    assign nxt_o  = nxt;
    assign mod_o  = cur.mod;
    assign len_o  = cur.len;
    assign base_o = cur.base;
    assign bank_o = st_q.bank;

endmodule

// File: rtl/circ_agen.sv
module circ_agen
    import agen_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned SLOTS = 8,
    parameter int unsigned NGEN  = 2,
    localparam int unsigned IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned GW   = (NGEN > 1) ? $clog2(NGEN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NGEN-1:0]     bank_sel_i,
    input  logic [NGEN-1:0]     req_i,
    input  logic [NGEN*IW-1:0]  idx_i,
    output logic [NGEN*AW-1:0]  addr_o,
    input  logic                cfg_we_i,
    input  logic [GW-1:0]       cfg_gen_i,
    input  logic                cfg_bank_i,
    input  logic [1:0]          cfg_kind_i,
    input  logic [IW-1:0]       cfg_idx_i,
    input  logic [AW-1:0]       cfg_wdata_i,
    output logic [AW-1:0]       cfg_rdata_o
);
    logic [NGEN-1:0][AW-1:0] rd_all;
    logic [NGEN-1:0][AW-1:0] nxt_all;
    logic [NGEN-1:0][AW-1:0] mod_all;
    logic [NGEN-1:0][AW-1:0] len_all;
    logic [NGEN-1:0][AW-1:0] base_all;
    logic [NGEN-1:0]         bank_act;
    reg_kind_e               kind;

    assign kind = reg_kind_e'(cfg_kind_i);

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic we_g;
        assign we_g = cfg_we_i && (cfg_gen_i == GW'(g));

        agen_unit #(.AW(AW), .SLOTS(SLOTS)) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank_sel_i (bank_sel_i[g]),
            .req_i      (req_i[g]),
            .idx_i      (idx_i[g*IW +: IW]),
            .we_i       (we_g),
            .cfg_bank_i (cfg_bank_i),
            .cfg_kind_i (kind),
            .cfg_idx_i  (cfg_idx_i),
            .wdata_i    (cfg_wdata_i),
            .rdata_o    (rd_all[g]),
            .addr_o     (addr_o[g*AW +: AW]),
            .nxt_o      (nxt_all[g]),
            .mod_o      (mod_all[g]),
            .len_o      (len_all[g]),
            .base_o     (base_all[g]),
            .bank_o     (bank_act[g])
        );
    end

    assign cfg_rdata_o = rd_all[cfg_gen_i];

endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned SLOTS = 8,
    parameter int unsigned NGEN  = 2,
    localparam int unsigned IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned GW   = (NGEN > 1) ? $clog2(NGEN) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NGEN-1:0]         req_i,
    input logic [NGEN*AW-1:0]      addr_o,
    input logic [NGEN-1:0][AW-1:0] nxt_all,
    input logic [NGEN-1:0][AW-1:0] mod_all,
    input logic [NGEN-1:0][AW-1:0] len_all,
    input logic [NGEN-1:0][AW-1:0] base_all,
    input logic [NGEN-1:0]         bank_act,
    input logic                    cfg_we_i,
    input logic [GW-1:0]           cfg_gen_i,
    input logic                    cfg_bank_i,
    input logic [1:0]              cfg_kind_i,
    input logic [IW-1:0]           cfg_idx_i,
    input logic [AW-1:0]           cfg_rdata_o
);
    for (genvar g = 0; g < NGEN; g++) begin : g_chk
        logic [AW-1:0] a;
        logic [AW-1:0] mag;
        logic [AW+1:0] lo;
        logic [AW+1:0] hi;
        logic [AW+1:0] ax;
        logic [AW+1:0] nx;
        logic          in_buf;
        logic          step_ok;

        assign a       = addr_o[g*AW +: AW];
        assign mag     = mod_all[g][AW-1] ? (-mod_all[g]) : mod_all[g];
        assign lo      = {2'b00, base_all[g]};
        assign hi      = {2'b00, base_all[g]} + {2'b00, len_all[g]};
        assign ax      = {2'b00, a};
        assign nx      = {2'b00, nxt_all[g]};
        assign in_buf  = (ax >= lo) && (ax < hi);
        assign step_ok = (len_all[g] != '0) && (mag <= len_all[g]);

        // R3: a pointer inside its buffer stays inside after post-modify
        p_in_buffer_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[g] && step_ok && in_buf) |-> ((nx >= lo) && (nx < hi)));

        // R4: zero length gives plain modular post-modify
        p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[g] && (len_all[g] == '0)) |-> (nxt_all[g] == a + mod_all[g]));

        // R1: address output is always driven
        p_addr_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !$isunknown(a));
    end

    // R7: inactive-bank registers hold while nobody writes them
    p_inactive_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && (cfg_bank_i != bank_act[cfg_gen_i])) |=>
        (!($stable(cfg_gen_i) && $stable(cfg_bank_i) && $stable(cfg_kind_i)
           && $stable(cfg_idx_i) && $stable(bank_act)) || $stable(cfg_rdata_o)));

endmodule

bind circ_agen circ_agen_chk #(.AW(AW), .SLOTS(SLOTS), .NGEN(NGEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .addr_o      (addr_o),
    .nxt_all     (nxt_all),
    .mod_all     (mod_all),
    .len_all     (len_all),
    .base_all    (base_all),
    .bank_act    (bank_act),
    .cfg_we_i    (cfg_we_i),
    .cfg_gen_i   (cfg_gen_i),
    .cfg_bank_i  (cfg_bank_i),
    .cfg_kind_i  (cfg_kind_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/circ_agen_tb.sv
`timescale 1ns/1ps
module circ_agen_tb;
    localparam logic [1:0] K_PTR  = 2'd0;
    localparam logic [1:0] K_MOD  = 2'd1;
    localparam logic [1:0] K_LEN  = 2'd2;
    localparam logic [1:0] K_BASE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [1:0]  req = '0;
    logic [5:0]  idx = '0;
    logic [63:0] addr;
    logic        cfg_we = 1'b0;
    logic        cfg_gen = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    circ_agen u_dut (
        .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel), .req_i(req),
        .idx_i(idx), .addr_o(addr), .cfg_we_i(cfg_we), .cfg_gen_i(cfg_gen),
        .cfg_bank_i(cfg_bank), .cfg_kind_i(cfg_kind), .cfg_idx_i(cfg_idx),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata)
    );

    function automatic logic [31:0] model_next(logic [31:0] p, logic [31:0] m,
                                               logic [31:0] l, logic [31:0] b);
        longint s;
        s = longint'(p) + longint'($signed(m));
        if (l != 0) begin
            if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
            else if (s < longint'(b))           s = s + longint'(l);
        end
        return s[31:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int g, input logic b, input logic [1:0] k,
                             input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_gen = 1'(g); cfg_bank = b; cfg_kind = k;
        cfg_idx = s; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int g, input logic b, input logic [1:0] k,
                            input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b0; cfg_gen = 1'(g); cfg_bank = b; cfg_kind = k; cfg_idx = s;
        #1 d = cfg_rdata;
    endtask

    task automatic run_buf(input int g, input logic [2:0] s, input logic [31:0] b,
                           input int len, input int mod, input int steps);
        logic [31:0] p;
        logic [31:0] m;
        logic [31:0] rd;
        m = 32'(mod);
        cfg_write(g, 1'b0, K_LEN, s, 32'(len));
        cfg_write(g, 1'b0, K_MOD, s, m);
        cfg_write(g, 1'b0, K_BASE, s, b);
        p = b;
        for (int k = 0; k < steps; k++) begin
            @(negedge clk);
            req[g] = 1'b1;
            idx[g*3 +: 3] = s;
            #1 chk("R3 R1 circular address", addr[g*32 +: 32], p);
            p = model_next(p, m, 32'(len), b);
        end
        @(negedge clk);
        req[g] = 1'b0;
        cfg_read(g, 1'b0, K_PTR, s, rd);
        chk("R2 pointer after final update", rd, p);
    endtask

    initial begin
        #500000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] p0;
        logic [31:0] p1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 reset state
        #1 chk("R8 reset address gen0", addr[31:0], 32'h0);
        chk("R8 reset address gen1", addr[63:32], 32'h0);
        cfg_read(1, 1'b1, K_BASE, 3'd7, rd);
        chk("R8 reset secondary base", rd, 32'h0);
        cfg_read(0, 1'b0, K_MOD, 3'd3, rd);
        chk("R8 reset primary modifier", rd, 32'h0);

        // R3 sweep: odd lengths, unaligned bases, both step signs
        for (int g = 0; g < 2; g++) begin
            for (int len = 1; len <= 7; len++) begin
                for (int mod = -len; mod <= len; mod++) begin
                    run_buf(g, 3'(len), (g == 0) ? 32'h0000_1003 : 32'hFFFF_FFE5,
                            len, mod, 2 * len + 3);
                end
            end
        end

        // R4 linear mode with zero length
        cfg_write(0, 1'b0, K_LEN, 3'd0, 32'h0);
        cfg_write(0, 1'b0, K_MOD, 3'd0, 32'hFFFF_FFFD);
        cfg_write(0, 1'b0, K_BASE, 3'd0, 32'h2);
        @(negedge clk); req[0] = 1'b1; idx[2:0] = 3'd0;
        #1 chk("R4 linear step 0", addr[31:0], 32'h2);
        @(negedge clk); #1 chk("R4 linear wraps through zero", addr[31:0], 32'hFFFF_FFFF);
        @(negedge clk); #1 chk("R4 linear step 2", addr[31:0], 32'hFFFF_FFFC);
        @(negedge clk); req[0] = 1'b0;
        cfg_write(0, 1'b0, K_MOD, 3'd0, 32'h5);
        cfg_write(0, 1'b0, K_BASE, 3'd0, 32'hFFFF_FFFE);
        @(negedge clk); req[0] = 1'b1;
        #1 chk("R4 linear top", addr[31:0], 32'hFFFF_FFFE);
        @(negedge clk); #1 chk("R4 linear overflow", addr[31:0], 32'h3);
        @(negedge clk); #1 chk("R4 linear step", addr[31:0], 32'h8);
        @(negedge clk); req[0] = 1'b0;

        // R5 base write loads pointer
        cfg_write(1, 1'b1, K_BASE, 3'd6, 32'hABCD_0001);
        cfg_read(1, 1'b1, K_PTR, 3'd6, rd);
        chk("R5 base write loads pointer", rd, 32'hABCD_0001);
        cfg_read(1, 1'b1, K_BASE, 3'd6, rd);
        chk("R11 base readback", rd, 32'hABCD_0001);

        // R6 / R7 bank switching on gen1 slot 2
        cfg_write(1, 1'b0, K_LEN, 3'd2, 32'd5);
        cfg_write(1, 1'b0, K_MOD, 3'd2, 32'd2);
        cfg_write(1, 1'b0, K_BASE, 3'd2, 32'h100);
        cfg_write(1, 1'b1, K_LEN, 3'd2, 32'd3);
        cfg_write(1, 1'b1, K_MOD, 3'd2, 32'hFFFF_FFFF);
        cfg_write(1, 1'b1, K_BASE, 3'd2, 32'h205);
        @(negedge clk); bank_sel[1] = 1'b1; req[1] = 1'b1; idx[5:3] = 3'd2;
        #1 chk("R6 R1 old bank used in switching cycle", addr[63:32], 32'h100);
        @(negedge clk);
        #1 chk("R6 secondary bank active next cycle", addr[63:32], 32'h205);
        @(negedge clk); req[1] = 1'b0;
        cfg_read(1, 1'b0, K_PTR, 3'd2, rd);
        chk("R7 primary pointer kept while secondary active", rd, 32'h102);
        cfg_read(1, 1'b1, K_PTR, 3'd2, rd);
        chk("R3 R6 secondary wrapped upward", rd, 32'h207);
        @(negedge clk); bank_sel[1] = 1'b0; req[1] = 1'b1;
        #1 chk("R6 secondary still used in switch-back cycle", addr[63:32], 32'h207);
        @(negedge clk);
        #1 chk("R6 R7 primary restored", addr[63:32], 32'h102);
        @(negedge clk); req[1] = 1'b0;
        cfg_read(1, 1'b1, K_PTR, 3'd2, rd);
        chk("R7 secondary kept after switch-back", rd, 32'h206);

        // R9 write versus update collision on gen0 slot 5
        cfg_write(0, 1'b0, K_LEN, 3'd5, 32'd4);
        cfg_write(0, 1'b0, K_MOD, 3'd5, 32'd1);
        cfg_write(0, 1'b0, K_BASE, 3'd5, 32'h40);
        @(negedge clk); req[0] = 1'b1; idx[2:0] = 3'd5;
        cfg_we = 1'b1; cfg_gen = 1'b0; cfg_bank = 1'b0; cfg_kind = K_PTR;
        cfg_idx = 3'd5; cfg_wdata = 32'h42;
        #1 chk("R9 address in collision cycle", addr[31:0], 32'h40);
        @(negedge clk); req[0] = 1'b0; cfg_we = 1'b0;
        cfg_read(0, 1'b0, K_PTR, 3'd5, rd);
        chk("R9 pointer write wins over update", rd, 32'h42);
        @(negedge clk); req[0] = 1'b1;
        cfg_we = 1'b1; cfg_kind = K_MOD; cfg_wdata = 32'd2;
        #1 chk("R9 address before modifier write", addr[31:0], 32'h42);
        @(negedge clk); cfg_we = 1'b0;
        #1 chk("R9 old modifier used by same-cycle update", addr[31:0], 32'h43);
        @(negedge clk); req[0] = 1'b0;
        #1 chk("R9 R3 new modifier used next", addr[31:0], 32'h41);
        @(negedge clk); req[0] = 1'b1;
        cfg_we = 1'b1; cfg_kind = K_BASE; cfg_wdata = 32'h80;
        @(negedge clk); req[0] = 1'b0; cfg_we = 1'b0;
        cfg_read(0, 1'b0, K_PTR, 3'd5, rd);
        chk("R9 R5 base write wins over update", rd, 32'h80);

        // R10 both generators at once
        cfg_write(0, 1'b0, K_LEN, 3'd1, 32'd3);
        cfg_write(0, 1'b0, K_MOD, 3'd1, 32'd1);
        cfg_write(0, 1'b0, K_BASE, 3'd1, 32'h10);
        cfg_write(1, 1'b0, K_LEN, 3'd1, 32'd6);
        cfg_write(1, 1'b0, K_MOD, 3'd1, 32'hFFFF_FFFC);
        cfg_write(1, 1'b0, K_BASE, 3'd1, 32'h21);
        p0 = 32'h10; p1 = 32'h21;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); req = 2'b11; idx = {3'd1, 3'd1};
            #1 chk("R10 gen0 address", addr[31:0], p0);
            chk("R10 gen1 address", addr[63:32], p1);
            p0 = model_next(p0, 32'd1, 32'd3, 32'h10);
            p1 = model_next(p1, 32'hFFFF_FFFC, 32'd6, 32'h21);
        end
        @(negedge clk); req = 2'b00;

        // R11 readback of modifier and length
        cfg_read(1, 1'b0, K_MOD, 3'd1, rd);
        chk("R11 modifier readback", rd, 32'hFFFF_FFFC);
        cfg_read(1, 1'b0, K_LEN, 3'd1, rd);
        chk("R11 length readback", rd, 32'd6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule